// File: doc/BRIEF.md
# Next-PC and Branch Unit

This block works out, with no clock, the address of the next instruction for a 32-bit RISC core. Its inputs are the current program counter, the fetched instruction word and the values of the two source registers named by that instruction. Its output is the next program counter. When the instruction is a call, it also gives the return address and a strobe that tells the register file to write that address into the link register (register 31).

The decode logic reads the major opcode, the function field and a sub-operation field. From these and a few comparison flags that the datapath supplies, it picks one of four sources for the next PC: sequential, region-absolute, register or PC-relative. The address arithmetic wraps modulo 2^32.

Top module: `next_pc_unit`

## Requirements
- R1: An instruction that is not a control transfer sets pcNext to pcCur+4 and holds linkWe low. The opcode is in bits 31:26. This covers an opcode-0 instruction whose function field (bits 5:0) is anything other than 0x08.
- R2: Opcode 0x02 is an absolute jump. pcNext is bits 31:28 of pcCur+4, then bits 25:0 of the instruction, then two zero bits. When pcCur+4 has moved into the next 256 MB region, that new region is the one used.
- R3: Opcode 0x00 with function 0x08 sets pcNext to rsVal.
- R4: Opcode 0x04 branches when rsVal equals rtVal. Opcode 0x05 branches when they differ.
- R5: A taken branch sets pcNext to pcCur+4 plus the sign-extended 16-bit offset (bits 15:0) shifted left by two, so negative offsets move backwards. An untaken branch gives pcCur+4.
- R6: Opcode 0x01 takes its condition from bits 20:16. Value 0 branches when rsVal is negative. Value 1 branches when rsVal is zero or positive. Any other value falls through to pcCur+4.
- R7: Opcode 0x06 branches when rsVal is less than or equal to zero. Opcode 0x07 branches when rsVal is greater than zero. rsVal is read as two's complement with bit 31 as the sign, and rtVal has no effect on these two opcodes.
- R8: Opcode 0x03 jumps exactly as R2 does and raises linkWe. linkVal carries pcCur+8. linkWe is low for every other opcode.
- R9: All address sums wrap modulo 2^32. For example, pcCur = 0xFFFFFFFC falls through to 0x00000000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pcCur | input | 32 | Address of the current instruction |
| instr | input | 32 | Current instruction word |
| rsVal | input | 32 | Value of the first source register |
| rtVal | input | 32 | Value of the second source register |
| pcNext | output | 32 | Address of the next instruction |
| linkWe | output | 1 | Write strobe for the link register |
| linkVal | output | 32 | Return address, pcCur+8 |

## Verification
The embedded assertions check several properties for every instruction word. At most one non-sequential source is selected at a time. A link write happens only together with a region-absolute target that keeps the upper four bits of pcCur+4. linkVal always equals pcCur+8. Every target other than a register jump keeps the word alignment of pcCur. Whether a particular condition is taken or untaken, the exact arithmetic of negative offsets, crossing into a new region and wraparound at the top of the address space can only be shown by the bench's directed scenarios.

// File: rtl/npc_pkg.sv
package npc_pkg;
  localparam int XLEN = 32;

  localparam logic [5:0] OP_SPECIAL = 6'h00;
  localparam logic [5:0] OP_ZCMP    = 6'h01;
  localparam logic [5:0] OP_JUMP    = 6'h02;
  localparam logic [5:0] OP_CALL    = 6'h03;
  localparam logic [5:0] OP_BREQ    = 6'h04;
  localparam logic [5:0] OP_BRNE    = 6'h05;
  localparam logic [5:0] OP_BRLEZ   = 6'h06;
  localparam logic [5:0] OP_BRGTZ   = 6'h07;
  localparam logic [5:0] FN_JREG    = 6'h08;
  localparam logic [4:0] SUB_LTZ    = 5'd0;
  localparam logic [4:0] SUB_GEZ    = 5'd1;

  typedef struct packed {
    logic useRegion;
    logic useReg;
    logic useBranch;
    logic linkWe;
  } npc_strobe_t;

  typedef struct packed {
    logic srcEqual;
    logic srcNeg;
    logic srcZero;
  } npc_flags_t;
endpackage

// File: rtl/npc_control.sv
module npc_control
  import npc_pkg::*;
(
  input  logic [31:0]  instr,
  input  npc_flags_t   flags,
  output npc_strobe_t  strobes
);
  logic [5:0] opField;
  logic [5:0] fnField;
  logic [4:0] subField;
  logic       condHit;

  assign opField  = instr[31:26];
  assign fnField  = instr[5:0];
  assign subField = instr[20:16];

  always_comb begin
    condHit = 1'b0;
    unique case (opField)
      OP_BREQ:  condHit = flags.srcEqual;
      OP_BRNE:  condHit = !flags.srcEqual;
      OP_BRLEZ: condHit = flags.srcNeg || flags.srcZero;
      OP_BRGTZ: condHit = !flags.srcNeg && !flags.srcZero;
      OP_ZCMP: begin
        if (subField == SUB_LTZ)      condHit = flags.srcNeg;
        else if (subField == SUB_GEZ) condHit = !flags.srcNeg;
        else                          condHit = 1'b0;
      end
      default:  condHit = 1'b0;
    endcase
  end

  always_comb begin
    strobes = '0;
    strobes.useRegion = (opField == OP_JUMP) || (opField == OP_CALL);
    strobes.linkWe    = (opField == OP_CALL);
    strobes.useReg    = (opField == OP_SPECIAL) && (fnField == FN_JREG);
    strobes.useBranch = condHit;
  end

  // R1: the non-sequential sources never overlap
  always_comb begin
    a_r1_single_source: assert ($onehot0({strobes.useRegion, strobes.useReg, strobes.useBranch}))
      else $error("more than one next-PC source selected");
  end
endmodule

// File: rtl/npc_datapath.sv
module npc_datapath
  import npc_pkg::*;
#(
  parameter int W     = XLEN,
  parameter int TGT_W = 26,
  parameter int OFF_W = 16
) (
  input  logic [W-1:0] pcCur,
  input  logic [31:0]  instr,
  input  logic [W-1:0] rsVal,
  input  logic [W-1:0] rtVal,
  input  npc_strobe_t  strobes,
  output npc_flags_t   flags,
  output logic [W-1:0] pcNext,
  output logic [W-1:0] linkVal
);
  localparam int REGION_W = W - TGT_W - 2;
  localparam int EXT_W    = W - OFF_W - 2;

  logic [W-1:0] pcPlus4;
  logic [W-1:0] regionTgt;
  logic [W-1:0] branchTgt;
  logic [W-1:0] offsetExt;

  assign pcPlus4   = pcCur + W'(4);
  assign linkVal   = pcPlus4 + W'(4);
  assign offsetExt = {{EXT_W{instr[OFF_W-1]}}, instr[OFF_W-1:0], 2'b00};
  assign branchTgt = pcPlus4 + offsetExt;

  generate
    if (REGION_W > 0) begin : g_region
      assign regionTgt = {pcPlus4[W-1 -: REGION_W], instr[TGT_W-1:0], 2'b00};
    end else begin : g_flat
      assign regionTgt = W'({instr[TGT_W-1:0], 2'b00});
    end
  endgenerate

  assign flags.srcEqual = (rsVal == rtVal);
  assign flags.srcNeg   = rsVal[W-1];
  assign flags.srcZero  = (rsVal == '0);

  always_comb begin
    if (strobes.useReg)         pcNext = rsVal;
    else if (strobes.useRegion) pcNext = regionTgt;
    else if (strobes.useBranch) pcNext = branchTgt;
    else                        pcNext = pcPlus4;
  end

  // R5: every target except a register jump keeps word alignment
  always_comb begin
    if (!strobes.useReg)
      a_r5_aligned: assert (pcNext[1:0] == pcCur[1:0])
        else $error("alignment lost");
  end
endmodule

// File: rtl/next_pc_unit.sv
module next_pc_unit
  import npc_pkg::*;
(
  input  logic [31:0] pcCur,
  input  logic [31:0] instr,
  input  logic [31:0] rsVal,
  input  logic [31:0] rtVal,
  output logic [31:0] pcNext,
  output logic        linkWe,
  output logic [31:0] linkVal
);
  npc_strobe_t strobes;
  npc_flags_t  flags;

  npc_control u_ctrl (
    .instr   (instr),
    .flags   (flags),
    .strobes (strobes)
  );

  npc_datapath #(.W(32)) u_dp (
    .pcCur   (pcCur),
    .instr   (instr),
    .rsVal   (rsVal),
    .rtVal   (rtVal),
    .strobes (strobes),
    .flags   (flags),
    .pcNext  (pcNext),
    .linkVal (linkVal)
  );

  assign linkWe = strobes.linkWe;

  logic [31:0] seqAddr;
  assign seqAddr = pcCur + 32'd4;

  always_comb begin
    // R8: return address is always two words ahead
    a_r8_link_value: assert (linkVal == pcCur + 32'd8)
      else $error("link value wrong");
    // R8: a link write comes only with a region-absolute target
    if (linkWe)
      a_r8_link_target: assert (pcNext == {seqAddr[31:28], instr[25:0], 2'b00})
        else $error("call target wrong");
    // R2: jumps keep the region of PC+4
    if (instr[31:26] == OP_JUMP)
      a_r2_region_kept: assert (pcNext[31:28] == seqAddr[31:28] && !linkWe)
        else $error("jump region wrong");
    // R1: opcodes outside the control set fall through
    if (instr[31:26] > OP_BRGTZ)
      a_r1_fall_through: assert (pcNext == seqAddr && !linkWe)
        else $error("sequential flow broken");
  end
endmodule

// File: tb/test_next_pc_unit.sv
module test_next_pc_unit;
  logic        clk = 1'b0;
  logic [31:0] pcCur = '0, instr = '0, rsVal = '0, rtVal = '0;
  logic [31:0] pcNext, linkVal;
  logic        linkWe;
  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  always #4 clk = ~clk;

  next_pc_unit i_next_pc_unit (
    .pcCur(pcCur), .instr(instr), .rsVal(rsVal), .rtVal(rtVal),
    .pcNext(pcNext), .linkWe(linkWe), .linkVal(linkVal)
  );

  function automatic logic [31:0] mkI(logic [5:0] op, logic [4:0] sub, logic [15:0] imm);
    return {op, 5'd3, sub, imm};
  endfunction

  function automatic logic [31:0] mkJ(logic [5:0] op, logic [25:0] tgt);
    return {op, tgt};
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic apply(logic [31:0] pc, logic [31:0] ins, logic [31:0] a, logic [31:0] b);
    @(negedge clk);
    pcCur = pc; instr = ins; rsVal = a; rtVal = b;
    #2;
  endtask

  task automatic t_idle();
    apply(32'h100, 32'h0, 32'h0, 32'h0);
    chk("R1 idle pc", pcNext, 32'h104);
    chk("R1 idle link", {31'd0, linkWe}, 32'd0);
  endtask

  task automatic t_seq();
    apply(32'h400, mkI(6'h09, 5'd0, 16'h0005), 32'h5, 32'h7);
    chk("R1 alu imm", pcNext, 32'h404);
    apply(32'h400, {6'h00, 5'd1, 5'd2, 5'd3, 5'd0, 6'h21}, 32'h4000, 32'h0);
    chk("R1 op0 other func", pcNext, 32'h404);
    chk("R1 op0 no link", {31'd0, linkWe}, 32'd0);
  endtask

  task automatic t_jump();
    apply(32'h2000_0010, mkJ(6'h02, 26'h0ABCDEF), 32'h0, 32'h0);
    chk("R2 jump", pcNext, 32'h2000_0000 | (32'h0ABCDEF << 2));
    apply(32'h2FFF_FFFC, mkJ(6'h02, 26'h0000004), 32'h0, 32'h0);
    chk("R2 region crossing", pcNext, 32'h3000_0010);
  endtask

  task automatic t_jreg();
    apply(32'h800, {6'h00, 5'd4, 15'd0, 6'h08}, 32'hDEAD_BEE0, 32'h0);
    chk("R3 jr", pcNext, 32'hDEAD_BEE0);
  endtask

  task automatic t_eqne();
    apply(32'h1000, mkI(6'h04, 5'd5, 16'h0003), 32'd9, 32'd9);
    chk("R4 beq taken", pcNext, 32'h1000 + 4 + 12);
    apply(32'h1000, mkI(6'h04, 5'd5, 16'h0003), 32'd9, 32'd8);
    chk("R4 beq untaken", pcNext, 32'h1004);
    apply(32'h1000, mkI(6'h05, 5'd5, 16'h0003), 32'd9, 32'd8);
    chk("R4 bne taken", pcNext, 32'h1010);
    apply(32'h1000, mkI(6'h05, 5'd5, 16'h0003), 32'd9, 32'd9);
    chk("R4 bne untaken", pcNext, 32'h1004);
  endtask

  task automatic t_offset();
    apply(32'h1000, mkI(6'h04, 5'd5, 16'hFFFE), 32'd1, 32'd1);
    chk("R5 negative offset", pcNext, 32'h1000 + 4 - 8);
    apply(32'h1000, mkI(6'h04, 5'd5, 16'h8000), 32'd1, 32'd1);
    chk("R5 most negative", pcNext, 32'h1004 - 32'h20000);
  endtask

  task automatic t_zcmp();
    apply(32'h200, mkI(6'h01, 5'd0, 16'h0002), 32'hFFFF_FFFF, 32'h0);
    chk("R6 ltz taken", pcNext, 32'h20C);
    apply(32'h200, mkI(6'h01, 5'd0, 16'h0002), 32'h0, 32'h0);
    chk("R6 ltz zero untaken", pcNext, 32'h204);
    apply(32'h200, mkI(6'h01, 5'd1, 16'h0002), 32'h0, 32'h0);
    chk("R6 gez zero taken", pcNext, 32'h20C);
    apply(32'h200, mkI(6'h01, 5'd1, 16'h0002), 32'hFFFF_FFFB, 32'h0);
    chk("R6 gez neg untaken", pcNext, 32'h204);
    apply(32'h200, mkI(6'h01, 5'd2, 16'h0002), 32'hFFFF_FFFF, 32'h0);
    chk("R6 other subop", pcNext, 32'h204);
  endtask

  task automatic t_lezgtz();
    apply(32'h300, mkI(6'h06, 5'd0, 16'h0001), 32'h0, 32'h5);
    chk("R7 lez zero", pcNext, 32'h308);
    apply(32'h300, mkI(6'h06, 5'd0, 16'h0001), 32'h8000_0000, 32'h0);
    chk("R7 lez min", pcNext, 32'h308);
    apply(32'h300, mkI(6'h06, 5'd0, 16'h0001), 32'h1, 32'h1);
    chk("R7 lez positive", pcNext, 32'h304);
    apply(32'h300, mkI(6'h07, 5'd0, 16'h0001), 32'h1, 32'h0);
    chk("R7 gtz positive", pcNext, 32'h308);
    apply(32'h300, mkI(6'h07, 5'd0, 16'h0001), 32'h0, 32'h9);
    chk("R7 gtz zero", pcNext, 32'h304);
    apply(32'h300, mkI(6'h07, 5'd0, 16'h0001), 32'h8000_0000, 32'h0);
    chk("R7 gtz min", pcNext, 32'h304);
  endtask

  task automatic t_call();
    apply(32'h5000_0020, mkJ(6'h03, 26'h0000100), 32'h0, 32'h0);
    chk("R8 call pc", pcNext, 32'h5000_0400);
    chk("R8 call link we", {31'd0, linkWe}, 32'd1);
    chk("R8 call link value", linkVal, 32'h5000_0028);
    apply(32'h5000_0020, mkJ(6'h02, 26'h0000100), 32'h0, 32'h0);
    chk("R8 plain jump no link", {31'd0, linkWe}, 32'd0);
  endtask

  task automatic t_wrap();
    apply(32'hFFFF_FFFC, mkI(6'h0D, 5'd0, 16'h0), 32'h0, 32'h0);
    chk("R9 wrap seq", pcNext, 32'h0);
    chk("R9 wrap link", linkVal, 32'h4);
    apply(32'hFFFF_FFF8, mkI(6'h04, 5'd5, 16'h0004), 32'h2, 32'h2);
    chk("R9 wrap branch", pcNext, 32'h0000_000C);
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    t_idle();
    t_seq();
    t_jump();
    t_jreg();
    t_eqne();
    t_offset();
    t_zcmp();
    t_lezgtz();
    t_call();
    t_wrap();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule